// File: doc/BRIEF.md
# Trace Packet FIFO with Overflow Policy

This block takes packets from two trace producers, one for instruction flow and one for data accesses, and funnels them into a single bounded FIFO. A slower sink drains the FIFO through a valid/ready output. When the producers generate trace faster than the sink can drain it, the block applies a selectable overflow policy instead of simply refusing writes. The first policy discards data-access packets once occupancy crosses a programmable level, which keeps room for program-flow packets. The second raises a stall request toward the processor so that no trace is lost. With neither policy active, any packet that meets a full FIFO is thrown away and is later represented by one explicit gap packet in the stream.

Each producer holds its packet until its ready is high. Ready means the packet was taken, whether it was stored or discarded. The FIFO has one write per cycle. An optional cycle-accurate mode follows every stored instruction packet with a cycle-count packet, and that packet uses a write slot of its own. Each stored entry carries a 2-bit kind code next to its payload, so the sink can tell the four packet types apart.

Top module: `trace_ovf_fifo`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid`, `out_gap` and `stall_req` are low.
- R2: Stored packets leave in the order they were written. `out_kind` carries the kind code (0 = instruction, 1 = data, 2 = cycle count, 3 = gap) and `out_data` carries the payload.
- R3: When both producers are valid in a cycle with nothing pending, the instruction packet is taken and `dat_ready` stays low.
- R4: With both policies off, a packet that arrives while occupancy equals DEPTH is taken and discarded. In the first later cycle with free space, before any other packet, exactly one gap packet is written. Its payload is the number of packets lost since the last gap packet.
- R5: With suppression on and occupancy at or above `cfg_afull`, a data packet that wins the write slot is taken and dropped. No gap packet follows.
- R6: With suppression on and occupancy below `cfg_afull`, data packets are stored normally.
- R7: With only the stall policy on, `stall_req` rises one cycle after occupancy reaches `cfg_afull`. It stays high until the cycle after occupancy has fallen to `cfg_release` or below.
- R8: With the stall policy on and the FIFO full, both producers see ready low. No packet is lost and no gap packet is produced.
- R9: With both policies on, data is still suppressed from `cfg_afull`, but `stall_req` rises only once occupancy reaches DEPTH minus STALL_MARGIN.
- R10: In cycle-accurate mode, the write that follows each stored instruction packet is a cycle-count packet. Both readies are low in that cycle. Its payload is the number of clock cycles since the previous stored instruction packet.
- R11: With cycle-accurate mode off, no cycle-count packets appear, and instruction packets can be stored on consecutive cycles.
- R12: `out_gap` is high exactly when the head packet on the output is a gap packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction-flow packet offered |
| ins_data | input | PW | Instruction-flow payload |
| ins_ready | output | 1 | Instruction packet taken (stored or discarded) |
| dat_valid | input | 1 | Data-access packet offered |
| dat_data | input | PW | Data-access payload |
| dat_ready | output | 1 | Data packet taken (stored or discarded) |
| cfg_suppress | input | 1 | Enable data suppression near full |
| cfg_stall | input | 1 | Enable stall-request policy |
| cfg_cycacc | input | 1 | Enable cycle-count packets |
| cfg_afull | input | CW | Almost-full occupancy level |
| cfg_release | input | CW | Occupancy level that releases the stall |
| out_valid | output | 1 | Head packet available |
| out_ready | input | 1 | Sink takes the head packet |
| out_kind | output | 2 | Kind code of the head packet |
| out_data | output | PW | Payload of the head packet |
| out_gap | output | 1 | Head packet is a gap marker |
| stall_req | output | 1 | Processor stall request |

## Verification
A wrong pointer or occupancy count shows up at the output within one drain as a packet out of order, a repeated packet or a missing packet. It also moves the cycle in which `stall_req` changes or data starts to be dropped, and that change is visible one cycle after the occupancy edge. A stale pending flag for a gap or a cycle-count packet shows up at once: a ready stays low for a cycle where it should be high, or an unexpected kind code appears in the drained stream. A wrong loss count shows as a gap payload that does not equal the number of packets refused while the FIFO was full.

// File: rtl/trace_fifo_pkg.sv
package trace_fifo_pkg;

  typedef enum logic [1:0] {
    PK_INSN = 2'd0,
    PK_DATA = 2'd1,
    PK_CYC  = 2'd2,
    PK_GAP  = 2'd3
  } pkt_kind_e;

endpackage

// File: rtl/trace_pkt_fifo.sv
module trace_pkt_fifo #(
  parameter int EW    = 10,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] occ_q, occ_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    occ_d    = occ_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign head  = mem[rd_ptr_q];
  assign occ   = occ_q;
  assign empty = (occ_q == '0);
  assign full  = (occ_q == CW'(DEPTH));

endmodule

// File: rtl/trace_stall_ctl.sv
module trace_stall_ctl #(
  parameter int DEPTH        = 8,
  parameter int STALL_MARGIN = 2,
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic          cfg_stall,
  input  logic          cfg_suppress,
  input  logic [CW-1:0] cfg_afull,
  input  logic [CW-1:0] cfg_release,
  output logic          stall_req
);

  localparam logic [CW-1:0] BOTH_LVL = CW'(DEPTH - STALL_MARGIN);

  logic          stall_q, stall_d;
  logic [CW-1:0] set_lvl;

  always_comb begin
    set_lvl = cfg_suppress ? BOTH_LVL : cfg_afull;
    if (!cfg_stall) begin
      stall_d = 1'b0;
    end else if (occ >= set_lvl) begin
      stall_d = 1'b1;
    end else if (occ <= cfg_release) begin
      stall_d = 1'b0;
    end else begin
      stall_d = stall_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else begin
      stall_q <= stall_d;
    end
  end

  assign stall_req = stall_q;

endmodule

// File: rtl/trace_cyc_count.sv
module trace_cyc_count #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [PW-1:0] cnt
);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart) begin
      cnt_d = PW'(1);
    end else if (&cnt_q) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/trace_ovf_fifo.sv
module trace_ovf_fifo
  import trace_fifo_pkg::*;
#(
  parameter int PW           = 8,
  parameter int DEPTH        = 8,
  parameter int STALL_MARGIN = 2,
  localparam int CW          = $clog2(DEPTH + 1),
  localparam int EW          = PW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [PW-1:0] ins_data,
  output logic          ins_ready,
  input  logic          dat_valid,
  input  logic [PW-1:0] dat_data,
  output logic          dat_ready,
  input  logic          cfg_suppress,
  input  logic          cfg_stall,
  input  logic          cfg_cycacc,
  input  logic [CW-1:0] cfg_afull,
  input  logic [CW-1:0] cfg_release,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [PW-1:0] out_data,
  output logic          out_gap,
  output logic          stall_req
);

  logic [CW-1:0] occ;
  logic          fifo_empty, fifo_full;
  logic [EW-1:0] head;
  logic          wr_en, pop;
  pkt_kind_e     wr_kind;
  logic [PW-1:0] wr_pay;
  logic          ins_wr, cyc_done, gap_wr, lost, suppress_now;

  logic          cyc_pend_q, cyc_pend_d;
  logic [PW-1:0] cyc_val_q, cyc_val_d;
  logic          gap_pend_q, gap_pend_d;
  logic [PW-1:0] lost_q, lost_d;
  logic [PW-1:0] cyc_cnt;

  assign suppress_now = cfg_suppress && (occ >= cfg_afull);

  // Write-slot arbitration: pending cycle count, then gap, then instruction, then data.
  always_comb begin
    wr_en     = 1'b0;
    wr_kind   = PK_INSN;
    wr_pay    = ins_data;
    ins_ready = 1'b0;
    dat_ready = 1'b0;
    ins_wr    = 1'b0;
    cyc_done  = 1'b0;
    gap_wr    = 1'b0;
    lost      = 1'b0;
    if (cyc_pend_q) begin
      if (!fifo_full) begin
        wr_en    = 1'b1;
        wr_kind  = PK_CYC;
        wr_pay   = cyc_val_q;
        cyc_done = 1'b1;
      end else if (!cfg_stall) begin
        cyc_done = 1'b1;
        lost     = 1'b1;
      end
    end else if (gap_pend_q && !fifo_full) begin
      wr_en   = 1'b1;
      wr_kind = PK_GAP;
      wr_pay  = lost_q;
      gap_wr  = 1'b1;
    end else if (ins_valid) begin
      if (!fifo_full) begin
        wr_en     = 1'b1;
        ins_ready = 1'b1;
        ins_wr    = 1'b1;
      end else if (!cfg_stall) begin
        ins_ready = 1'b1;
        lost      = 1'b1;
      end
    end else if (dat_valid) begin
      if (suppress_now) begin
        dat_ready = 1'b1;
      end else if (!fifo_full) begin
        wr_en     = 1'b1;
        wr_kind   = PK_DATA;
        wr_pay    = dat_data;
        dat_ready = 1'b1;
      end else if (!cfg_stall) begin
        dat_ready = 1'b1;
        lost      = 1'b1;
      end
    end
  end

  always_comb begin
    cyc_pend_d = cyc_pend_q;
    if (cyc_done) begin
      cyc_pend_d = 1'b0;
    end else if (ins_wr && cfg_cycacc) begin
      cyc_pend_d = 1'b1;
    end
    cyc_val_d = ins_wr ? cyc_cnt : cyc_val_q;

    gap_pend_d = gap_pend_q;
    lost_d     = lost_q;
    if (gap_wr) begin
      gap_pend_d = 1'b0;
      lost_d     = '0;
    end else if (lost) begin
      gap_pend_d = 1'b1;
      lost_d     = (&lost_q) ? lost_q : lost_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_pend_q <= 1'b0;
      cyc_val_q  <= '0;
      gap_pend_q <= 1'b0;
      lost_q     <= '0;
    end else begin
      cyc_pend_q <= cyc_pend_d;
      cyc_val_q  <= cyc_val_d;
      gap_pend_q <= gap_pend_d;
      lost_q     <= lost_d;
    end
  end

  trace_pkt_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_en),
    .push_data ({wr_kind, wr_pay}),
    .pop       (pop),
    .head      (head),
    .occ       (occ),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  trace_stall_ctl #(.DEPTH(DEPTH), .STALL_MARGIN(STALL_MARGIN)) u_stall (
    .clk          (clk),
    .rst_n        (rst_n),
    .occ          (occ),
    .cfg_stall    (cfg_stall),
    .cfg_suppress (cfg_suppress),
    .cfg_afull    (cfg_afull),
    .cfg_release  (cfg_release),
    .stall_req    (stall_req)
  );

  trace_cyc_count #(.PW(PW)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ins_wr),
    .cnt     (cyc_cnt)
  );

  assign pop       = out_ready && !fifo_empty;
  assign out_valid = !fifo_empty;
  assign out_kind  = head[EW-1 -: 2];
  assign out_data  = head[PW-1:0];
  assign out_gap   = !fifo_empty && (head[EW-1 -: 2] == 2'(PK_GAP));

endmodule

// File: rtl/trace_ovf_fifo_chk.sv
module trace_ovf_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic          dat_valid,
  input logic          dat_ready,
  input logic          cfg_stall,
  input logic          cfg_cycacc,
  input logic          out_valid,
  input logic          out_ready,
  input logic          stall_req,
  input logic [CW-1:0] occ
);

  // R1: idle outputs during reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !stall_req));

  // R2: occupancy never exceeds the storage
  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R3: instruction packet wins over data
  a_r3_ins_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && dat_valid) |-> !dat_ready);

  // R7: stall only follows an enabled stall policy
  a_r7_stall_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> $past(cfg_stall));

  // R8: full FIFO with stall policy refuses the instruction packet
  a_r8_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stall && occ == CW'(DEPTH) && !out_ready) |-> !ins_ready);

  // R10: a stored instruction packet blocks both producers next cycle
  a_r10_cyc_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cycacc && ins_valid && ins_ready && occ != CW'(DEPTH)) |=> (!ins_ready && !dat_ready));

endmodule

bind trace_ovf_fifo trace_ovf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .dat_valid  (dat_valid),
  .dat_ready  (dat_ready),
  .cfg_stall  (cfg_stall),
  .cfg_cycacc (cfg_cycacc),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .stall_req  (stall_req),
  .occ        (occ)
);

// File: tb/test_trace_ovf_fifo.sv
module test_trace_ovf_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int PW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0, dat_valid = 1'b0;
  logic [PW-1:0] ins_data = '0, dat_data = '0;
  logic          ins_ready, dat_ready;
  logic          cfg_suppress = 1'b0, cfg_stall = 1'b0, cfg_cycacc = 1'b0;
  logic [CW-1:0] cfg_afull = '0, cfg_release = '0;
  logic          out_valid, out_gap, stall_req;
  logic          out_ready = 1'b0;
  logic [1:0]    out_kind;
  logic [PW-1:0] out_data;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  trace_ovf_fifo #(.PW(PW), .DEPTH(DEPTH), .STALL_MARGIN(2)) i_trace_ovf_fifo (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready),
    .dat_valid(dat_valid), .dat_data(dat_data), .dat_ready(dat_ready),
    .cfg_suppress(cfg_suppress), .cfg_stall(cfg_stall), .cfg_cycacc(cfg_cycacc),
    .cfg_afull(cfg_afull), .cfg_release(cfg_release),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_data(out_data), .out_gap(out_gap), .stall_req(stall_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit sup, input bit stl, input bit cyc,
                          input int afull, input int rel);
    @(negedge clk);
    rst_n = 1'b0;
    ins_valid = 1'b0; dat_valid = 1'b0; out_ready = 1'b0;
    cfg_suppress = sup; cfg_stall = stl; cfg_cycacc = cyc;
    cfg_afull = CW'(afull); cfg_release = CW'(rel);
    exp_q.delete();
    repeat (2) @(negedge clk);
    #1;
    chk(!out_valid && !stall_req && !out_gap, "R1 idle in reset",
        {out_valid, stall_req, out_gap}, 0);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && !stall_req && !out_gap, "R1 idle after release",
        {out_valid, stall_req, out_gap}, 0);
  endtask

  task automatic step(input logic iv, input logic [PW-1:0] id,
                      input logic dv, input logic [PW-1:0] dd,
                      output logic ir, output logic dr, output int edge_no);
    @(negedge clk);
    ins_valid = iv; ins_data = id; dat_valid = dv; dat_data = dd;
    #1;
    ir = ins_ready; dr = dat_ready; edge_no = ecnt;
    @(posedge clk);
    #1;
    ins_valid = 1'b0; dat_valid = 1'b0;
  endtask

  task automatic pop1();
    logic [10:0] e;
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    e = exp_q.pop_front();
    chk(out_valid, "R2 head valid", out_valid, 1);
    if (out_valid) begin
      chk(out_kind == e[9:8], "R2 kind", out_kind, e[9:8]);
      if (!e[10]) chk(out_data == e[7:0], "R2 payload", out_data, e[7:0]);
      chk(out_gap == (e[9:8] == 2'd3), "R12 gap flag", out_gap, (e[9:8] == 2'd3));
    end
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) pop1();
    @(negedge clk);
    #1;
    chk(!out_valid, tag, out_valid, 0);
  endtask

  initial begin
    logic ir, dr;
    int e0, e1, e2;

    // S1: ordering, priority, no cycle packets (R2 R3 R11)
    do_reset(0, 0, 0, 8, 0);
    step(1, 8'h01, 1, 8'hA1, ir, dr, e0);
    chk(ir && !dr, "R3 insn wins", {ir, dr}, 2'b10);
    exp_q.push_back({1'b0, 2'd0, 8'h01});
    step(1, 8'h02, 1, 8'hA1, ir, dr, e0);
    chk(ir && !dr, "R11 back-to-back insn", {ir, dr}, 2'b10);
    exp_q.push_back({1'b0, 2'd0, 8'h02});
    step(0, 8'h00, 1, 8'hA1, ir, dr, e0);
    chk(dr, "R2 data taken", dr, 1);
    exp_q.push_back({1'b0, 2'd1, 8'hA1});
    step(0, 8'h00, 1, 8'hA2, ir, dr, e0);
    exp_q.push_back({1'b0, 2'd1, 8'hA2});
    drain("R11 no extra packets");

    // S2: loss with no policy, single gap packet (R4)
    do_reset(0, 0, 0, 8, 0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1, PW'(8'h10 + i), 0, 8'h00, ir, dr, e0);
      exp_q.push_back({1'b0, 2'd0, PW'(8'h10 + i)});
    end
    for (int i = 0; i < 3; i++) begin
      step(1, PW'(8'h20 + i), 0, 8'h00, ir, dr, e0);
      chk(ir, "R4 full packet taken", ir, 1);
    end
    pop1();
    step(1, 8'h30, 0, 8'h00, ir, dr, e0);
    chk(!ir, "R4 gap written first", ir, 0);
    exp_q.push_back({1'b0, 2'd3, 8'd3});
    drain("R4 one gap only");

    // S3: suppression threshold (R5 R6)
    do_reset(1, 0, 0, 4, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 8'h00, 1, PW'(8'h40 + i), ir, dr, e0);
      chk(dr, "R6 data below level", dr, 1);
      exp_q.push_back({1'b0, 2'd1, PW'(8'h40 + i)});
    end
    step(0, 8'h00, 1, 8'h4F, ir, dr, e0);
    chk(dr, "R5 data dropped taken", dr, 1);
    step(1, 8'h50, 0, 8'h00, ir, dr, e0);
    chk(ir, "R5 insn still stored", ir, 1);
    exp_q.push_back({1'b0, 2'd0, 8'h50});
    drain("R5 no gap after drop");

    // S4: stall only, hysteresis and no loss (R7 R8)
    do_reset(0, 1, 0, 5, 2);
    for (int i = 0; i < DEPTH; i++) begin
      step(1, PW'(8'h60 + i), 0, 8'h00, ir, dr, e0);
      exp_q.push_back({1'b0, 2'd0, PW'(8'h60 + i)});
      if (i == 4) chk(!stall_req, "R7 stall not yet", stall_req, 0);
      if (i == 5) chk(stall_req, "R7 stall raised", stall_req, 1);
    end
    step(1, 8'h6F, 1, 8'h6E, ir, dr, e0);
    chk(!ir && !dr, "R8 full refuses", {ir, dr}, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      pop1();
      if (k == 6) chk(stall_req, "R7 stall held", stall_req, 1);
      if (k == 7) chk(!stall_req, "R7 stall released", stall_req, 0);
    end
    @(negedge clk);
    #1;
    chk(!out_valid, "R8 no gap under stall", out_valid, 0);

    // S5: both policies (R9)
    do_reset(1, 1, 0, 3, 1);
    for (int i = 0; i < 3; i++) begin
      step(1, PW'(8'h70 + i), 0, 8'h00, ir, dr, e0);
      exp_q.push_back({1'b0, 2'd0, PW'(8'h70 + i)});
    end
    step(0, 8'h00, 1, 8'h7F, ir, dr, e0);
    chk(dr, "R9 data suppressed", dr, 1);
    for (int i = 3; i < 6; i++) begin
      step(1, PW'(8'h70 + i), 0, 8'h00, ir, dr, e0);
      exp_q.push_back({1'b0, 2'd0, PW'(8'h70 + i)});
    end
    chk(!stall_req, "R9 no stall at afull", stall_req, 0);
    step(0, 8'h00, 0, 8'h00, ir, dr, e0);
    chk(stall_req, "R9 stall at margin", stall_req, 1);
    for (int k = 0; k < 6; k++) pop1();
    chk(!stall_req, "R9 stall released", stall_req, 0);
    drain("R9 drained");

    // S6: cycle-accurate packets (R10)
    do_reset(0, 0, 1, 8, 0);
    step(1, 8'h81, 0, 8'h00, ir, dr, e0);
    exp_q.push_back({1'b0, 2'd0, 8'h81});
    exp_q.push_back({1'b1, 2'd2, 8'h00});
    step(1, 8'h82, 1, 8'h99, ir, dr, e1);
    chk(!ir && !dr, "R10 slot blocked", {ir, dr}, 0);
    step(1, 8'h82, 0, 8'h00, ir, dr, e1);
    chk(ir, "R10 insn after count", ir, 1);
    exp_q.push_back({1'b0, 2'd0, 8'h82});
    exp_q.push_back({1'b0, 2'd2, PW'(e1 - e0)});
    repeat (4) step(0, 8'h00, 0, 8'h00, ir, dr, e2);
    step(1, 8'h83, 0, 8'h00, ir, dr, e2);
    chk(ir, "R10 third insn", ir, 1);
    exp_q.push_back({1'b0, 2'd0, 8'h83});
    exp_q.push_back({1'b0, 2'd2, PW'(e2 - e1)});
    step(0, 8'h00, 0, 8'h00, ir, dr, e0);
    drain("R10 drained");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule